// File: doc/BRIEF.md
# Fetch-Stage Macro-Op Fusion Detector

The block looks at the start of a 64-bit fetch window made of four 16-bit parcels, each with a valid bit. It decodes the first instruction and the instruction right after it. Each instruction may be a 16-bit compressed form or a 32-bit full form. When the two form a known fusible pair, the block emits one fused micro-op. A fused micro-op carries an operation class, up to four register numbers, a combined immediate, a memory size field and an index scale. When the pair does not match, the first instruction leaves the block alone, as its raw bits. The consumed-byte count tells the fetch logic how far to advance.

Every fusion is qualified by register numbers. The first instruction must write a register other than x0. The second instruction must read that register as its base or source. For load pairs, the load must overwrite that same register, which leaves the intermediate value dead. The result is registered, so it appears one clock after the window is sampled.

Top module: `fuse_detect`

## Requirements
- R1: While rst_ni is low, every output is zero.
- R2: The micro-op for the window and valid mask sampled at a rising clock edge appears on the outputs after that edge and holds until the next edge.
- R3: A lui rd=t followed by addi rd=t, rs1=t (t not x0) fuses to class 1. The output has rd=t and imm = (upper20 << 12) + sign-extended low12, taken modulo 2^32. The rs1, rs2, rs3, sub and scale outputs are 0.
- R4: An auipc rd=t followed by addi rd=t, rs1=t fuses to class 2. It has the same rd and imm rule as R3.
- R5: A lui rd=t followed by an add with rd=t, where exactly one source is t, fuses to class 3. The output has rd=t, rs1 = the other source and imm = upper20 << 12.
- R6: An add (scale 0) or shNadd (scale N, N=1..3) writing t, followed by a load whose base and destination are both t, fuses to class 4. The address is rs1 + (rs2 << scale) + imm. For add, rs1 and rs2 are its sources. For shNadd, rs1 is its unshifted source and rs2 its shifted source. The imm output is the load offset and sub is the load size code (compressed word = 2, double = 3). An addi writing t, followed by such a load, fuses to class 5. It has rs1 = the addi source and imm = addi imm + load offset.
- R7: An add or shNadd writing t, followed by a store whose base is t and whose data register is not t, fuses to class 6. The output has rd=t, rs1, rs2 and scale as in R6, rs3 = the store data register, imm = the store offset and sub = the store size code. A store whose data register is t does not fuse.
- R8: Fusion works for all four width mixes: compressed/compressed, full/compressed, compressed/full and full/full. The compressed forms recognised are addi, lui, add, and word and double loads and stores. A compressed register field r names x(8+r).
- R9: A pair that fails any register rule passes the first instruction through. So does a pair whose first instruction writes x0. Pass-through gives uop_vld_o=1, uop_fused_o=0 and class 0. It sets the register, imm, sub and scale outputs to 0. uop_insn_o holds the raw first instruction, zero-extended when it is compressed, and is 0 for a fused micro-op.
- R10: If parcel 0 is invalid, the outputs are uop_vld_o=0 and used_o=0, with every other output 0. The same holds if the first instruction is full-width and parcel 1 is invalid. If any parcel of the second instruction is invalid, the first instruction passes through.
- R11: used_o is the byte count taken: 2 or 4 for pass-through, and the sum of both widths (4, 6 or 8) for a fused pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| win_i | input | 64 | Fetch window, parcel 0 in bits 15:0 |
| win_vld_i | input | 4 | Valid bit per parcel |
| uop_vld_o | output | 1 | A micro-op is present |
| uop_fused_o | output | 1 | The micro-op is a fused pair |
| uop_cls_o | output | 3 | Operation class (0 pass, 1..6 as in requirements) |
| uop_rd_o | output | 5 | Destination register |
| uop_rs1_o | output | 5 | First source / base register |
| uop_rs2_o | output | 5 | Second source / index register |
| uop_rs3_o | output | 5 | Store data register |
| uop_imm_o | output | 32 | Combined immediate |
| uop_sub_o | output | 3 | Memory size code |
| uop_scale_o | output | 2 | Index shift amount |
| used_o | output | 4 | Bytes consumed |
| uop_insn_o | output | 32 | Raw instruction on pass-through |

## Verification
Every output is registered once, so the micro-op for a window is due exactly one rising edge after the window is applied. The bench changes the window at a falling edge. It compares all outputs at the next falling edge, half a cycle after the registering edge, against an expectation computed from that window alone. Every clock is compared in this way, both for the directed pairs and for a long run of generated pairs that mix widths and register choices. Directed cases also check individual fields by value for each width mix, for each register-rule failure and for each partially valid window.

// File: rtl/fuse_pkg.sv
package fuse_pkg;
  localparam int RW    = 5;
  localparam int IMM_W = 32;
  localparam int INS_W = 32;

  localparam logic [6:0] OP_LUI   = 7'b0110111;
  localparam logic [6:0] OP_AUIPC = 7'b0010111;
  localparam logic [6:0] OP_IMM   = 7'b0010011;
  localparam logic [6:0] OP_REG   = 7'b0110011;
  localparam logic [6:0] OP_LOAD  = 7'b0000011;
  localparam logic [6:0] OP_STORE = 7'b0100011;

  typedef enum logic [2:0] {
    K_NONE, K_LUI, K_AUIPC, K_ADDI, K_ADD, K_SHADD, K_LOAD, K_STORE
  } kind_e;

  typedef enum logic [2:0] {
    C_PASS  = 3'd0,
    C_LI    = 3'd1,
    C_PCREL = 3'd2,
    C_ADDHI = 3'd3,
    C_LDX   = 3'd4,
    C_LDO   = 3'd5,
    C_STX   = 3'd6
  } cls_e;

  typedef struct packed {
    kind_e            kind;
    logic [RW-1:0]    rd;
    logic [RW-1:0]    rs1;
    logic [RW-1:0]    rs2;
    logic [IMM_W-1:0] imm;
    logic [1:0]       sc;
    logic [2:0]       f3;
  } dec_t;
endpackage

// File: rtl/fuse_dec.sv
module fuse_dec
  import fuse_pkg::*;
(
  input  logic [INS_W-1:0] insn_i,
  output dec_t             dec_o,
  output logic             cmp_o
);
  logic [6:0]    op;
  logic [2:0]    f3;
  logic [6:0]    f7;
  logic [RW-1:0] rd, rs1, rs2, rdp, rs1p;
  logic [2:0]    cf3;
  logic [5:0]    cimm;

  assign op   = insn_i[6:0];
  assign f3   = insn_i[14:12];
  assign f7   = insn_i[31:25];
  assign rd   = insn_i[11:7];
  assign rs1  = insn_i[19:15];
  assign rs2  = insn_i[24:20];
  assign cf3  = insn_i[15:13];
  assign cimm = {insn_i[12], insn_i[6:2]};
  assign rdp  = {2'b01, insn_i[4:2]};
  assign rs1p = {2'b01, insn_i[9:7]};
  assign cmp_o = (insn_i[1:0] != 2'b11);

  always_comb begin
    dec_o = '0;
    dec_o.kind = K_NONE;
    if (!cmp_o) begin
      unique case (op)
        OP_LUI, OP_AUIPC: begin
          dec_o.kind = (op == OP_LUI) ? K_LUI : K_AUIPC;
          dec_o.rd   = rd;
          dec_o.imm  = {insn_i[31:12], 12'b0};
        end
        OP_IMM: if (f3 == 3'b000) begin
          dec_o.kind = K_ADDI;
          dec_o.rd   = rd;
          dec_o.rs1  = rs1;
          dec_o.imm  = {{20{insn_i[31]}}, insn_i[31:20]};
        end
        OP_REG: begin
          dec_o.rd  = rd;
          dec_o.rs1 = rs1;
          dec_o.rs2 = rs2;
          if (f7 == 7'b0000000 && f3 == 3'b000) dec_o.kind = K_ADD;
          else if (f7 == 7'b0010000 && f3[0] == 1'b0 && f3 != 3'b000) begin
            dec_o.kind = K_SHADD;
            dec_o.sc   = f3[2:1];
          end
        end
        OP_LOAD: if (f3 != 3'b111) begin
          dec_o.kind = K_LOAD;
          dec_o.rd   = rd;
          dec_o.rs1  = rs1;
          dec_o.imm  = {{20{insn_i[31]}}, insn_i[31:20]};
          dec_o.f3   = f3;
        end
        OP_STORE: if (!f3[2]) begin
          dec_o.kind = K_STORE;
          dec_o.rs1  = rs1;
          dec_o.rs2  = rs2;
          dec_o.imm  = {{20{insn_i[31]}}, insn_i[31:25], insn_i[11:7]};
          dec_o.f3   = f3;
        end
        default: ;
      endcase
    end else begin
      unique case (insn_i[1:0])
        2'b01: begin
          if (cf3 == 3'b000) begin
            dec_o.kind = K_ADDI;
            dec_o.rd   = rd;
            dec_o.rs1  = rd;
            dec_o.imm  = {{26{cimm[5]}}, cimm};
          end else if (cf3 == 3'b011 && rd != 5'd0 && rd != 5'd2 && cimm != 6'd0) begin
            dec_o.kind = K_LUI;
            dec_o.rd   = rd;
            dec_o.imm  = {{14{cimm[5]}}, cimm, 12'b0};
          end
        end
        2'b10: if (insn_i[15:12] == 4'b1001 && rd != 5'd0 && insn_i[6:2] != 5'd0) begin
          dec_o.kind = K_ADD;
          dec_o.rd   = rd;
          dec_o.rs1  = rd;
          dec_o.rs2  = insn_i[6:2];
        end
        2'b00: begin
          dec_o.rs1 = rs1p;
          dec_o.f3  = {2'b01, cf3[0]};
          dec_o.imm = cf3[0] ? {24'b0, insn_i[6:5], insn_i[12:10], 3'b0}
                             : {25'b0, insn_i[5], insn_i[12:10], insn_i[6], 2'b0};
          if (cf3[2:1] == 2'b01) begin
            dec_o.kind = K_LOAD;
            dec_o.rd   = rdp;
          end else if (cf3[2:1] == 2'b11) begin
            dec_o.kind = K_STORE;
            dec_o.rs2  = rdp;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/fuse_pair.sv
module fuse_pair
  import fuse_pkg::*;
(
  input  dec_t             a_i,
  input  dec_t             b_i,
  output logic             hit_o,
  output cls_e             cls_o,
  output logic [RW-1:0]    rd_o,
  output logic [RW-1:0]    rs1_o,
  output logic [RW-1:0]    rs2_o,
  output logic [RW-1:0]    rs3_o,
  output logic [IMM_W-1:0] imm_o,
  output logic [2:0]       sub_o,
  output logic [1:0]       sc_o
);
  logic [RW-1:0] t, base, idx;
  logic          b_reads_t, b_kills_t;
  logic          unused_fields;

  assign t         = a_i.rd;
  assign base      = (a_i.kind == K_SHADD) ? a_i.rs2 : a_i.rs1;
  assign idx       = (a_i.kind == K_SHADD) ? a_i.rs1 : a_i.rs2;
  assign b_reads_t = (b_i.rs1 == t);
  assign b_kills_t = (b_i.rd == t);
  assign unused_fields = ^{a_i.f3, b_i.sc};

  always_comb begin
    hit_o = 1'b0;
    cls_o = C_PASS;
    rd_o  = '0;
    rs1_o = '0;
    rs2_o = '0;
    rs3_o = '0;
    imm_o = '0;
    sub_o = '0;
    sc_o  = '0;
    if (t != '0) begin
      unique case (a_i.kind)
        K_LUI, K_AUIPC: begin
          if (b_i.kind == K_ADDI && b_reads_t && b_kills_t) begin
            hit_o = 1'b1;
            cls_o = (a_i.kind == K_LUI) ? C_LI : C_PCREL;
            rd_o  = t;
            imm_o = a_i.imm + b_i.imm;
          end else if (a_i.kind == K_LUI && b_i.kind == K_ADD && b_kills_t &&
                       (b_reads_t != (b_i.rs2 == t))) begin
            hit_o = 1'b1;
            cls_o = C_ADDHI;
            rd_o  = t;
            rs1_o = b_reads_t ? b_i.rs2 : b_i.rs1;
            imm_o = a_i.imm;
          end
        end
        K_ADD, K_SHADD: begin
          if (b_i.kind == K_LOAD && b_reads_t && b_kills_t) begin
            hit_o = 1'b1;
            cls_o = C_LDX;
          end else if (b_i.kind == K_STORE && b_reads_t && b_i.rs2 != t) begin
            hit_o = 1'b1;
            cls_o = C_STX;
            rs3_o = b_i.rs2;
          end
          if (hit_o) begin
            rd_o  = t;
            rs1_o = base;
            rs2_o = idx;
            imm_o = b_i.imm;
            sub_o = b_i.f3;
            sc_o  = a_i.sc;
          end
        end
        K_ADDI: begin
          if (b_i.kind == K_LOAD && b_reads_t && b_kills_t) begin
            hit_o = 1'b1;
            cls_o = C_LDO;
            rd_o  = t;
            rs1_o = a_i.rs1;
            imm_o = a_i.imm + b_i.imm;
            sub_o = b_i.f3;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/fuse_detect.sv
module fuse_detect
  import fuse_pkg::*;
#(
  parameter int PARCEL_W = 16,
  parameter int N_PARCEL = 4
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [PARCEL_W*N_PARCEL-1:0] win_i,
  input  logic [N_PARCEL-1:0]          win_vld_i,
  output logic                         uop_vld_o,
  output logic                         uop_fused_o,
  output logic [2:0]                   uop_cls_o,
  output logic [RW-1:0]                uop_rd_o,
  output logic [RW-1:0]                uop_rs1_o,
  output logic [RW-1:0]                uop_rs2_o,
  output logic [RW-1:0]                uop_rs3_o,
  output logic [IMM_W-1:0]             uop_imm_o,
  output logic [2:0]                   uop_sub_o,
  output logic [1:0]                   uop_scale_o,
  output logic [$clog2(2*N_PARCEL+1)-1:0] used_o,
  output logic [INS_W-1:0]             uop_insn_o
);
  localparam int WIN_W  = PARCEL_W * N_PARCEL;
  localparam int N_DEC  = N_PARCEL - 1;
  localparam int USED_W = $clog2(2*N_PARCEL+1);
  localparam int LEN_W  = USED_W - 1;

  dec_t dec   [N_DEC];
  logic cmp   [N_DEC];

  // one decoder per possible start parcel of either instruction
  for (genvar g = 0; g < N_DEC; g++) begin : g_dec
    fuse_dec u_dec (
      .insn_i (win_i[g*PARCEL_W +: INS_W]),
      .dec_o  (dec[g]),
      .cmp_o  (cmp[g])
    );
  end

  logic             c0, c1, ok1, ok2, fuse;
  logic [LEN_W-1:0] len1, len2;
  dec_t             second;

  assign c0     = cmp[0];
  assign len1   = c0 ? LEN_W'(1) : LEN_W'(2);
  assign ok1    = win_vld_i[0] && (c0 || win_vld_i[1]);
  assign second = c0 ? dec[1] : dec[2];
  assign c1     = c0 ? cmp[1] : cmp[2];
  assign len2   = c1 ? LEN_W'(1) : LEN_W'(2);
  assign ok2    = c0 ? (win_vld_i[1] && (c1 || win_vld_i[2]))
                     : (win_vld_i[2] && (c1 || win_vld_i[3]));

  logic             p_hit;
  cls_e             p_cls;
  logic [RW-1:0]    p_rd, p_rs1, p_rs2, p_rs3;
  logic [IMM_W-1:0] p_imm;
  logic [2:0]       p_sub;
  logic [1:0]       p_sc;

  fuse_pair u_pair (
    .a_i   (dec[0]),
    .b_i   (second),
    .hit_o (p_hit),
    .cls_o (p_cls),
    .rd_o  (p_rd),
    .rs1_o (p_rs1),
    .rs2_o (p_rs2),
    .rs3_o (p_rs3),
    .imm_o (p_imm),
    .sub_o (p_sub),
    .sc_o  (p_sc)
  );

  assign fuse = ok1 && ok2 && p_hit;

  logic [USED_W-1:0] used_n;
  logic [INS_W-1:0]  insn_n;

  always_comb begin
    used_n = '0;
    if (fuse)     used_n = {len1 + len2, 1'b0};
    else if (ok1) used_n = {len1, 1'b0};
    insn_n = '0;
    if (ok1 && !fuse) insn_n = c0 ? {{(INS_W-PARCEL_W){1'b0}}, win_i[PARCEL_W-1:0]}
                                  : win_i[INS_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      uop_vld_o   <= 1'b0;
      uop_fused_o <= 1'b0;
      uop_cls_o   <= '0;
      uop_rd_o    <= '0;
      uop_rs1_o   <= '0;
      uop_rs2_o   <= '0;
      uop_rs3_o   <= '0;
      uop_imm_o   <= '0;
      uop_sub_o   <= '0;
      uop_scale_o <= '0;
      used_o      <= '0;
      uop_insn_o  <= '0;
    end else begin
      uop_vld_o   <= ok1;
      uop_fused_o <= fuse;
      uop_cls_o   <= fuse ? p_cls : C_PASS;
      uop_rd_o    <= fuse ? p_rd  : '0;
      uop_rs1_o   <= fuse ? p_rs1 : '0;
      uop_rs2_o   <= fuse ? p_rs2 : '0;
      uop_rs3_o   <= fuse ? p_rs3 : '0;
      uop_imm_o   <= fuse ? p_imm : '0;
      uop_sub_o   <= fuse ? p_sub : '0;
      uop_scale_o <= fuse ? p_sc  : '0;
      used_o      <= used_n;
      uop_insn_o  <= insn_n;
    end
  end

  // R2
  lat_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !win_vld_i[0] |=> !uop_vld_o);
  // R2
  lat_short_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_vld_i[0] && win_i[1:0] != 2'b11) |=> uop_vld_o);
  // R11
  used_fused_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uop_fused_o |-> (used_o >= USED_W'(4) && used_o <= USED_W'(8) && !used_o[0]));
  // R9
  pass_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uop_vld_o && !uop_fused_o) |->
      ((used_o == USED_W'(2) || used_o == USED_W'(4)) && uop_cls_o == 3'(C_PASS)));
  // R10
  idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !uop_vld_o |-> (used_o == '0 && !uop_fused_o));
  // R10
  used_vld_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uop_vld_o |=> 1'b1 ? (!uop_vld_o || 32'(used_o[USED_W-1:1]) <= $countones($past(win_vld_i))) : 1'b1);
  // R9
  fuse_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uop_fused_o |-> (uop_rd_o != '0 && uop_insn_o == '0));
endmodule

// File: tb/fuse_detect_bench.sv
`timescale 1ns/1ps
module fuse_detect_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [63:0] win_i = '0;
  logic [3:0]  win_vld_i = '0;
  logic        uop_vld_o, uop_fused_o;
  logic [2:0]  uop_cls_o, uop_sub_o;
  logic [4:0]  uop_rd_o, uop_rs1_o, uop_rs2_o, uop_rs3_o;
  logic [31:0] uop_imm_o, uop_insn_o;
  logic [1:0]  uop_scale_o;
  logic [3:0]  used_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  fuse_detect u_fuse_detect (
    .clk_i, .rst_ni, .win_i, .win_vld_i, .uop_vld_o, .uop_fused_o, .uop_cls_o,
    .uop_rd_o, .uop_rs1_o, .uop_rs2_o, .uop_rs3_o, .uop_imm_o, .uop_sub_o,
    .uop_scale_o, .used_o, .uop_insn_o
  );

  localparam int KN = 0, KLUI = 1, KAUI = 2, KADDI = 3, KADD = 4, KSH = 5, KLD = 6, KST = 7;

  // ---------- encoders ----------
  function automatic logic [31:0] e_lui(input logic [4:0] rd, input logic [19:0] u);
    return {u, rd, 7'b0110111};
  endfunction
  function automatic logic [31:0] e_auipc(input logic [4:0] rd, input logic [19:0] u);
    return {u, rd, 7'b0010111};
  endfunction
  function automatic logic [31:0] e_addi(input logic [4:0] rd, rs1, input logic [11:0] i);
    return {i, rs1, 3'b000, rd, 7'b0010011};
  endfunction
  function automatic logic [31:0] e_add(input logic [4:0] rd, rs1, rs2);
    return {7'b0, rs2, rs1, 3'b000, rd, 7'b0110011};
  endfunction
  function automatic logic [31:0] e_shadd(input int n, input logic [4:0] rd, rs1, rs2);
    return {7'b0010000, rs2, rs1, 3'(n * 2), rd, 7'b0110011};
  endfunction
  function automatic logic [31:0] e_ld(input logic [2:0] f3, input logic [4:0] rd, rs1, input logic [11:0] i);
    return {i, rs1, f3, rd, 7'b0000011};
  endfunction
  function automatic logic [31:0] e_st(input logic [2:0] f3, input logic [4:0] rs2, rs1, input logic [11:0] i);
    return {i[11:5], rs2, rs1, f3, i[4:0], 7'b0100011};
  endfunction
  function automatic logic [31:0] c_addi(input logic [4:0] rd, input logic [5:0] i);
    return {16'b0, 3'b000, i[5], rd, i[4:0], 2'b01};
  endfunction
  function automatic logic [31:0] c_lui(input logic [4:0] rd, input logic [5:0] i);
    return {16'b0, 3'b011, i[5], rd, i[4:0], 2'b01};
  endfunction
  function automatic logic [31:0] c_add(input logic [4:0] rd, rs2);
    return {16'b0, 4'b1001, rd, rs2, 2'b10};
  endfunction
  function automatic logic [31:0] c_mem(input bit st, input bit dbl, input logic [2:0] r, b, input logic [7:0] off);
    logic [15:0] x;
    x = {st, 1'b1, dbl, off[5:3], b, 2'b00, r, 2'b00};
    if (dbl) x[6:5] = off[7:6];
    else begin x[6] = off[2]; x[5] = off[6]; end
    return {16'b0, x};
  endfunction
  function automatic logic [63:0] pw(input logic [31:0] a, input logic [31:0] b);
    logic [63:0] w;
    w = '0;
    if (a[1:0] != 2'b11) begin w[15:0] = a[15:0]; w[47:16] = b; end
    else begin w[31:0] = a; w[63:32] = b; end
    return w;
  endfunction

  // ---------- reference ----------
  function automatic void mdec(input logic [31:0] x, output int k, output logic [4:0] rd, rs1, rs2,
                               output logic [31:0] im, output logic [1:0] sc, output logic [2:0] f3);
    logic [5:0] ci;
    k = KN; rd = 0; rs1 = 0; rs2 = 0; im = 0; sc = 0; f3 = 0;
    ci = {x[12], x[6:2]};
    if (x[1:0] == 2'b11) begin
      case (x[6:0])
        7'b0110111: begin k = KLUI; rd = x[11:7]; im = {x[31:12], 12'h0}; end
        7'b0010111: begin k = KAUI; rd = x[11:7]; im = {x[31:12], 12'h0}; end
        7'b0010011: if (x[14:12] == 0) begin
          k = KADDI; rd = x[11:7]; rs1 = x[19:15]; im = 32'(signed'(x[31:20]));
        end
        7'b0110011: begin
          rd = x[11:7]; rs1 = x[19:15]; rs2 = x[24:20];
          if (x[31:25] == 0 && x[14:12] == 0) k = KADD;
          if (x[31:25] == 7'b0010000 && (x[14:12] == 2 || x[14:12] == 4 || x[14:12] == 6)) begin
            k = KSH; sc = 2'(x[14:12] / 2);
          end
        end
        7'b0000011: if (x[14:12] != 7) begin
          k = KLD; rd = x[11:7]; rs1 = x[19:15]; im = 32'(signed'(x[31:20])); f3 = x[14:12];
        end
        7'b0100011: if (x[14] == 0) begin
          k = KST; rs1 = x[19:15]; rs2 = x[24:20]; f3 = x[14:12];
          im = 32'(signed'({x[31:25], x[11:7]}));
        end
        default: ;
      endcase
    end else if (x[1:0] == 2'b01 && x[15:13] == 0) begin
      k = KADDI; rd = x[11:7]; rs1 = x[11:7]; im = 32'(signed'(ci));
    end else if (x[1:0] == 2'b01 && x[15:13] == 3 && x[11:7] != 0 && x[11:7] != 2 && ci != 0) begin
      k = KLUI; rd = x[11:7]; im = 32'(signed'(ci)) << 12;
    end else if (x[1:0] == 2'b10 && x[15:12] == 9 && x[11:7] != 0 && x[6:2] != 0) begin
      k = KADD; rd = x[11:7]; rs1 = x[11:7]; rs2 = x[6:2];
    end else if (x[1:0] == 2'b00 && x[14] == 1) begin
      f3 = x[13] ? 3 : 2;
      rs1 = 5'd8 + 5'(x[9:7]);
      im = x[13] ? 32'({x[6:5], x[12:10], 3'b0}) : 32'({x[5], x[12:10], x[6], 2'b0});
      if (x[15]) begin k = KST; rs2 = 5'd8 + 5'(x[4:2]); end
      else begin k = KLD; rd = 5'd8 + 5'(x[4:2]); end
    end
  endfunction

  function automatic logic [97:0] model(input logic [63:0] w, input logic [3:0] v);
    logic [31:0] i0, i1;
    int n0, n1, p, ka, kb, cls;
    logic ok2, fz;
    logic [4:0] ard, ars1, ars2, brd, brs1, brs2, rd, r1, r2, r3;
    logic [31:0] aim, bim, im, insn;
    logic [1:0] asc, bsc, sc;
    logic [2:0] af3, bf3, sub;
    i0 = w[31:0];
    n0 = (i0[1:0] != 2'b11) ? 1 : 2;
    if (!v[0] || (n0 == 2 && !v[1])) return '0;
    p = n0;
    i1 = w[p*16 +: 32];
    n1 = (i1[1:0] != 2'b11) ? 1 : 2;
    ok2 = v[p] && (n1 == 1 || v[p+1]);
    mdec(i0, ka, ard, ars1, ars2, aim, asc, af3);
    mdec(i1, kb, brd, brs1, brs2, bim, bsc, bf3);
    cls = 0; rd = 0; r1 = 0; r2 = 0; r3 = 0; im = 0; sub = 0; sc = 0;
    if (ok2 && ard != 0) begin
      if ((ka == KLUI || ka == KAUI) && kb == KADDI && brs1 == ard && brd == ard) begin
        cls = (ka == KLUI) ? 1 : 2; rd = ard; im = aim + bim;
      end else if (ka == KLUI && kb == KADD && brd == ard && ((brs1 == ard) ^ (brs2 == ard))) begin
        cls = 3; rd = ard; r1 = (brs1 == ard) ? brs2 : brs1; im = aim;
      end else if ((ka == KADD || ka == KSH) && brs1 == ard &&
                   ((kb == KLD && brd == ard) || (kb == KST && brs2 != ard))) begin
        cls = (kb == KLD) ? 4 : 6; rd = ard;
        r1 = (ka == KSH) ? ars2 : ars1; r2 = (ka == KSH) ? ars1 : ars2;
        r3 = (kb == KST) ? brs2 : 5'd0; im = bim; sub = bf3; sc = asc;
      end else if (ka == KADDI && kb == KLD && brs1 == ard && brd == ard) begin
        cls = 5; rd = ard; r1 = ars1; im = aim + bim; sub = bf3;
      end
    end
    fz = (cls != 0);
    insn = fz ? 32'h0 : ((n0 == 1) ? {16'h0, i0[15:0]} : i0);
    return {1'b1, fz, 3'(cls), rd, r1, r2, r3, im, sub, sc, 4'(fz ? 2*(n0+n1) : 2*n0), insn};
  endfunction

  function automatic logic [97:0] actual();
    return {uop_vld_o, uop_fused_o, uop_cls_o, uop_rd_o, uop_rs1_o, uop_rs2_o, uop_rs3_o,
            uop_imm_o, uop_sub_o, uop_scale_o, used_o, uop_insn_o};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // drive at a falling edge, result due after the next rising edge
  task automatic step(input logic [63:0] w, input logic [3:0] v, input string tag);
    logic [97:0] e;
    win_i = w; win_vld_i = v;
    e = model(w, v);
    @(negedge clk_i);
    total++;
    if (actual() !== e) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, actual(), e);
    end
  endtask

  function automatic logic [4:0] rr();
    case ($urandom_range(3))
      0: return 5'd8;
      1: return 5'd9;
      2: return 5'd10;
      default: return ($urandom_range(7) == 0) ? 5'd0 : 5'd8;
    endcase
  endfunction

  function automatic logic [31:0] rnd_insn();
    logic [4:0] a, b, c;
    a = rr(); b = rr(); c = rr();
    case ($urandom_range(13))
      0:  return e_lui(a, 20'($urandom));
      1:  return e_auipc(a, 20'($urandom));
      2:  return e_addi(a, b, 12'($urandom));
      3:  return e_add(a, b, c);
      4:  return e_shadd($urandom_range(1, 3), a, b, c);
      5:  return e_ld(3'($urandom_range(6)), a, b, 12'($urandom));
      6:  return e_st(3'($urandom_range(3)), a, b, 12'($urandom));
      7:  return c_addi(a, 6'($urandom));
      8:  return c_lui(a, 6'($urandom));
      9:  return c_add(a, b);
      10: return c_mem(1'b0, 1'($urandom), a[2:0], b[2:0], 8'($urandom));
      11: return c_mem(1'b1, 1'($urandom), a[2:0], b[2:0], 8'($urandom));
      12: return $urandom;
      default: return {16'h0, 16'($urandom)};
    endcase
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    win_i = pw(e_lui(5'd5, 20'h12345), e_addi(5'd5, 5'd5, 12'hfff));
    win_vld_i = 4'hf;
    repeat (3) @(negedge clk_i);
    // R1: outputs cleared while held in reset
    chk("R1 vld", 32'(uop_vld_o), 0);
    chk("R1 used", 32'(used_o), 0);
    chk("R1 imm", uop_imm_o, 0);
    chk("R1 insn", uop_insn_o, 0);
    rst_ni = 1'b1;

    step(pw(e_lui(5'd5, 20'h12345), e_addi(5'd5, 5'd5, 12'hfff)), 4'hf, "R3 lui+addi");
    chk("R3 cls", 32'(uop_cls_o), 1);
    chk("R3 imm", uop_imm_o, 32'h12344fff);
    chk("R11 used full/full", 32'(used_o), 8);

    step(pw(e_auipc(5'd6, 20'h00001), e_addi(5'd6, 5'd6, 12'h800)), 4'hf, "R4 auipc+addi");
    chk("R4 cls", 32'(uop_cls_o), 2);
    chk("R4 imm", uop_imm_o, 32'h00000800);

    step(pw(e_lui(5'd7, 20'habcde), e_add(5'd7, 5'd9, 5'd7)), 4'hf, "R5 lui+add");
    chk("R5 cls", 32'(uop_cls_o), 3);
    chk("R5 rs1", 32'(uop_rs1_o), 9);
    chk("R5 imm", uop_imm_o, 32'habcde000);

    step(pw(e_shadd(2, 5'd10, 5'd11, 5'd12), e_ld(3'd2, 5'd10, 5'd10, 12'd8)), 4'hf, "R6 shadd+lw");
    chk("R6 cls", 32'(uop_cls_o), 4);
    chk("R6 base", 32'(uop_rs1_o), 12);
    chk("R6 index", 32'(uop_rs2_o), 11);
    chk("R6 scale", 32'(uop_scale_o), 2);
    chk("R6 imm", uop_imm_o, 8);

    step(pw(e_addi(5'd13, 5'd14, 12'd100), e_ld(3'd3, 5'd13, 5'd13, 12'd20)), 4'hf, "R6 addi+ld");
    chk("R6 ldo cls", 32'(uop_cls_o), 5);
    chk("R6 ldo imm", uop_imm_o, 120);
    chk("R6 ldo sub", 32'(uop_sub_o), 3);

    step(pw(e_add(5'd15, 5'd16, 5'd17), e_st(3'd3, 5'd18, 5'd15, 12'd0)), 4'hf, "R7 add+sd");
    chk("R7 cls", 32'(uop_cls_o), 6);
    chk("R7 rd", 32'(uop_rd_o), 15);
    chk("R7 rs3", 32'(uop_rs3_o), 18);

    step(pw(e_add(5'd15, 5'd16, 5'd17), e_st(3'd3, 5'd15, 5'd15, 12'd0)), 4'hf, "R7 data is temp");
    chk("R7 no fuse", 32'(uop_fused_o), 0);
    chk("R7 pass used", 32'(used_o), 4);

    step(pw(c_lui(5'd8, 6'd1), c_addi(5'd8, 6'd5)), 4'hf, "R8 c/c");
    chk("R8 c/c cls", 32'(uop_cls_o), 1);
    chk("R8 c/c imm", uop_imm_o, 32'h1005);
    chk("R8 c/c used", 32'(used_o), 4);

    step(pw(e_add(5'd9, 5'd20, 5'd21), c_mem(1'b0, 1'b0, 3'd1, 3'd1, 8'd4)), 4'hf, "R8 f/c");
    chk("R8 f/c cls", 32'(uop_cls_o), 4);
    chk("R8 f/c imm", uop_imm_o, 4);
    chk("R8 f/c used", 32'(used_o), 6);

    step(pw(c_add(5'd10, 5'd11), e_ld(3'd2, 5'd10, 5'd10, 12'd0)), 4'hf, "R8 c/f");
    chk("R8 c/f cls", 32'(uop_cls_o), 4);
    chk("R8 c/f rs2", 32'(uop_rs2_o), 11);
    chk("R8 c/f used", 32'(used_o), 6);

    step(pw(e_lui(5'd0, 20'h1), e_addi(5'd0, 5'd0, 12'd1)), 4'hf, "R9 x0 dest");
    chk("R9 x0 fused", 32'(uop_fused_o), 0);
    chk("R9 x0 insn", uop_insn_o, e_lui(5'd0, 20'h1));

    step(pw(e_lui(5'd5, 20'h1), e_addi(5'd6, 5'd5, 12'd1)), 4'hf, "R9 mismatch");
    chk("R9 mismatch cls", 32'(uop_cls_o), 0);
    chk("R9 mismatch used", 32'(used_o), 4);

    step(pw(c_addi(5'd8, 6'd3), 32'h0), 4'h1, "R9 compressed pass");
    chk("R9 c insn", uop_insn_o, c_addi(5'd8, 6'd3));
    chk("R11 c used", 32'(used_o), 2);

    step(pw(e_lui(5'd5, 20'h1), e_addi(5'd5, 5'd5, 12'd1)), 4'h0, "R10 empty");
    chk("R10 empty vld", 32'(uop_vld_o), 0);
    step(pw(e_lui(5'd5, 20'h1), e_addi(5'd5, 5'd5, 12'd1)), 4'h1, "R10 half first");
    chk("R10 half used", 32'(used_o), 0);
    step(pw(e_lui(5'd5, 20'h1), e_addi(5'd5, 5'd5, 12'd1)), 4'h7, "R10 half second");
    chk("R10 second cut", 32'(uop_fused_o), 0);
    chk("R10 second used", 32'(used_o), 4);

    for (int n = 0; n < 4000; n++) begin
      logic [31:0] a, b;
      logic [63:0] w;
      logic [3:0] v;
      a = rnd_insn(); b = rnd_insn();
      w = {$urandom, $urandom};
      if (a[1:0] != 2'b11) begin w[15:0] = a[15:0]; w[47:16] = b; end
      else begin w[31:0] = a; w[63:32] = b; end
      v = ($urandom_range(4) == 0) ? 4'($urandom) : 4'hf;
      step(w, v, "R2 random");
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule